// File: doc/BRIEF.md
# Frequency-Change Watchdog with Safe-Code Recovery

This block protects a clock generator against a hang after a bad frequency change. Software loads a timeout in units of 250 ms and then turns the watchdog on. From then on the counter steps down by one for each unit. The live count and the running state can be read at any moment. Writing the timeout again while the watchdog runs reloads the counter, and this write is how software keeps the watchdog alive.

When the count runs out, the block raises a sticky timeout status and holds an open-drain reset request low for one unit. It also turns off direct M/N divider programming. In the same step it hands the frequency-select path a fallback 5-bit code and a one-cycle load strobe. The fallback code is the programmed safe code when safe recovery is enabled. Otherwise it is the strap value latched at power-up.

The unit length comes from a timebase strobe `tick_i` and the parameter `TICKS_PER_UNIT`, the number of strobes that make one 250 ms unit. A short simulation can therefore use a few strobes per unit. The block has no data stream, so every pin is a plain control or status signal.

Top module: `freq_watchdog`

## Requirements
- R1: After reset the count reads 8 (a 2.0 s timeout), and the running, status, reset-request, M/N-enable and load-strobe outputs all read 0.
- R2: Writing 1 to the enable loads the count from the stored timeout and makes running read 1. While running, the count drops by exactly one after every `TICKS_PER_UNIT` timebase strobes.
- R3: When a running count would go below one, the count reads 0 and does not wrap. Running drops to 0 and the timeout status becomes 1 on the same edge.
- R4: The timeout status has no write path. It stays 1 until the next write of 1 to the enable, which clears it.
- R5: The reset request `rst_pull_o` (1 = pull the open-drain pin low) rises on the edge after expiry. It stays high for exactly `TICKS_PER_UNIT` strobes, so the low pulse on the pin lasts one unit.
- R6: Expiry clears the M/N programming enable. An M/N write in the expiry cycle loses to the clear.
- R7: At expiry `fs_load_o` pulses for one cycle. `fs_code_o` takes `safe_code_i` when `safe_en_i` is 1, or `strap_fs_i` when it is 0, and holds that value afterwards.
- R8: A timeout write reloads both the count and the unit prescaler. In the cycle where expiry would otherwise happen, the write wins, so no expiry occurs.
- R9: Writing 0 to the enable stops counting, and the count holds its value. Further strobes cause no expiry and no reset request.
- R10: A stored timeout of 0 expires after one unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Timebase strobe, one cycle wide |
| tmo_wr_i | input | 1 | Write strobe for the timeout value |
| tmo_wdata_i | input | 8 | Timeout in 250 ms units |
| en_wr_i | input | 1 | Write strobe for the enable bit |
| en_wdata_i | input | 1 | Enable value (1 = start, 0 = stop) |
| mn_wr_i | input | 1 | Write strobe for the M/N programming enable |
| mn_wdata_i | input | 1 | M/N programming enable value |
| safe_en_i | input | 1 | 1 = recover to safe code, 0 = recover to strap code |
| safe_code_i | input | 5 | Programmed safe frequency code |
| strap_fs_i | input | 5 | Frequency code latched from straps at power-up |
| count_o | output | 8 | Live count |
| running_o | output | 1 | 1 while counting down |
| timeout_o | output | 1 | Sticky timeout status |
| rst_pull_o | output | 1 | 1 = drive reset pin low |
| mn_en_o | output | 1 | M/N programming enable |
| fs_load_o | output | 1 | One-cycle strobe: load `fs_code_o` into frequency select |
| fs_code_o | output | 5 | Recovery frequency code |

## Verification
Two functions can fall in the same cycle. One is a keep-alive timeout write, or an M/N enable write, arriving on the very strobe that ends the last unit. The other is the expiry that this strobe would cause. The bench provokes both cases by driving the write together with that final strobe. For the keep-alive case it judges that running stays 1, the status stays 0 and the count shows the new value. For the M/N case it judges that the timeout is taken and the M/N enable reads 0. A stored timeout of 0 and a stop in the middle of a count are also driven, and the bench checks the exact strobe on which expiry occurs or stays absent.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int FS_W = 5;
  typedef logic [FS_W-1:0] fs_code_t;
endpackage

// File: rtl/wdg_unit_div.sv
module wdg_unit_div #(
  parameter int TICKS_PER_UNIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic tick,
  output logic unit_end
);
  localparam int PW = (TICKS_PER_UNIT > 1) ? $clog2(TICKS_PER_UNIT) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICKS_PER_UNIT - 1);

  logic [PW-1:0] pre_q;

  assign unit_end = run && tick && (pre_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pre_q <= '0;
    else if (clr || !run)    pre_q <= '0;
    else if (unit_end)       pre_q <= '0;
    else if (tick)           pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/wdg_countdown.sv
module wdg_countdown #(
  parameter int CNT_W     = 8,
  parameter int CNT_RESET = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmo_wr,
  input  logic [CNT_W-1:0] tmo_wdata,
  input  logic             en_wr,
  input  logic             en_wdata,
  input  logic             unit_end,
  output logic [CNT_W-1:0] cnt,
  output logic             running,
  output logic             timeout,
  output logic             load,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] tmo_q;
  logic             start;

  assign start  = en_wr && en_wdata;
  assign load   = tmo_wr || start;
  assign expire = running && unit_end && (cnt <= ONE) && !tmo_wr && !en_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_q   <= CNT_W'(CNT_RESET);
      cnt     <= CNT_W'(CNT_RESET);
      running <= 1'b0;
      timeout <= 1'b0;
    end else begin
      if (tmo_wr) tmo_q <= tmo_wdata;

      if (load)                             cnt <= tmo_wr ? tmo_wdata : tmo_q;
      else if (expire)                      cnt <= '0;
      else if (running && unit_end && !en_wr) cnt <= cnt - ONE;

      if (en_wr)       running <= en_wdata;
      else if (expire) running <= 1'b0;

      if (start)       timeout <= 1'b0;
      else if (expire) timeout <= 1'b1;
    end
  end

  AST_STATUS_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (timeout && !running && cnt == '0)); // R3
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !load) |=> cnt == '0); // R3
  AST_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load) |=> cnt <= $past(cnt)); // R2
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (running && !timeout)); // R4
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr && !en_wdata && !tmo_wr) |=> (!running && $stable(cnt))); // R9
endmodule

// File: rtl/wdg_reset_pulse.sv
module wdg_reset_pulse #(
  parameter int TICKS_PER_UNIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic expire,
  output logic rst_pull
);
  logic pulse_end;

  wdg_unit_div #(.TICKS_PER_UNIT(TICKS_PER_UNIT)) u_pulse_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (expire),
    .run      (rst_pull),
    .tick     (tick),
    .unit_end (pulse_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rst_pull <= 1'b0;
    else if (expire)    rst_pull <= 1'b1;
    else if (pulse_end) rst_pull <= 1'b0;
  end

  AST_PULL_AFTER_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> rst_pull); // R5
  AST_PULL_HOLDS_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_pull && !tick) |=> rst_pull); // R5
endmodule

// File: rtl/wdg_freq_recover.sv
module wdg_freq_recover
  import wdg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     expire,
  input  logic     mn_wr,
  input  logic     mn_wdata,
  input  logic     safe_en,
  input  fs_code_t safe_code,
  input  fs_code_t strap_fs,
  output logic     mn_en,
  output logic     fs_load,
  output fs_code_t fs_code
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mn_en   <= 1'b0;
      fs_load <= 1'b0;
      fs_code <= '0;
    end else begin
      if (expire)     mn_en <= 1'b0;
      else if (mn_wr) mn_en <= mn_wdata;
      fs_load <= expire;
      if (expire) fs_code <= safe_en ? safe_code : strap_fs;
    end
  end

  AST_MN_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !mn_en); // R6
  AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fs_load |=> !fs_load); // R7
  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !expire |=> $stable(fs_code)); // R7
endmodule

// File: rtl/freq_watchdog.sv
module freq_watchdog
  import wdg_pkg::*;
#(
  parameter int TICKS_PER_UNIT = 1000,
  parameter int CNT_W          = 8,
  parameter int CNT_RESET      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             tmo_wr_i,
  input  logic [CNT_W-1:0] tmo_wdata_i,
  input  logic             en_wr_i,
  input  logic             en_wdata_i,
  input  logic             mn_wr_i,
  input  logic             mn_wdata_i,
  input  logic             safe_en_i,
  input  logic [FS_W-1:0]  safe_code_i,
  input  logic [FS_W-1:0]  strap_fs_i,
  output logic [CNT_W-1:0] count_o,
  output logic             running_o,
  output logic             timeout_o,
  output logic             rst_pull_o,
  output logic             mn_en_o,
  output logic             fs_load_o,
  output logic [FS_W-1:0]  fs_code_o
);
  logic unit_end;
  logic load;
  logic expire;
  fs_code_t code_q;

  wdg_unit_div #(.TICKS_PER_UNIT(TICKS_PER_UNIT)) u_unit_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (load),
    .run      (running_o),
    .tick     (tick_i),
    .unit_end (unit_end)
  );

  wdg_countdown #(.CNT_W(CNT_W), .CNT_RESET(CNT_RESET)) u_countdown (
    .clk       (clk),
    .rst_n     (rst_n),
    .tmo_wr    (tmo_wr_i),
    .tmo_wdata (tmo_wdata_i),
    .en_wr     (en_wr_i),
    .en_wdata  (en_wdata_i),
    .unit_end  (unit_end),
    .cnt       (count_o),
    .running   (running_o),
    .timeout   (timeout_o),
    .load      (load),
    .expire    (expire)
  );

  wdg_reset_pulse #(.TICKS_PER_UNIT(TICKS_PER_UNIT)) u_reset_pulse (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_i),
    .expire   (expire),
    .rst_pull (rst_pull_o)
  );

  wdg_freq_recover u_freq_recover (
    .clk       (clk),
    .rst_n     (rst_n),
    .expire    (expire),
    .mn_wr     (mn_wr_i),
    .mn_wdata  (mn_wdata_i),
    .safe_en   (safe_en_i),
    .safe_code (safe_code_i),
    .strap_fs  (strap_fs_i),
    .mn_en     (mn_en_o),
    .fs_load   (fs_load_o),
    .fs_code   (code_q)
  );

  assign fs_code_o = code_q;

  AST_KEEPALIVE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (running_o && tmo_wr_i && !en_wr_i) |=> (running_o && !fs_load_o)); // R8
  AST_TIMEOUT_PULLS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_o) |-> (rst_pull_o && fs_load_o && !mn_en_o)); // R5
endmodule

// File: tb/freq_watchdog_tb_top.sv
`timescale 1ns/1ps
module freq_watchdog_tb_top;
  localparam int TPU = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0, tmo_wr_i = 1'b0, en_wr_i = 1'b0, en_wdata_i = 1'b0;
  logic       mn_wr_i = 1'b0, mn_wdata_i = 1'b0, safe_en_i = 1'b0;
  logic [7:0] tmo_wdata_i = '0;
  logic [4:0] safe_code_i = '0, strap_fs_i = '0;
  logic [7:0] count_o;
  logic       running_o, timeout_o, rst_pull_o, mn_en_o, fs_load_o;
  logic [4:0] fs_code_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  freq_watchdog #(.TICKS_PER_UNIT(TPU)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .tmo_wr_i(tmo_wr_i), .tmo_wdata_i(tmo_wdata_i),
    .en_wr_i(en_wr_i), .en_wdata_i(en_wdata_i),
    .mn_wr_i(mn_wr_i), .mn_wdata_i(mn_wdata_i),
    .safe_en_i(safe_en_i), .safe_code_i(safe_code_i), .strap_fs_i(strap_fs_i),
    .count_o(count_o), .running_o(running_o), .timeout_o(timeout_o),
    .rst_pull_o(rst_pull_o), .mn_en_o(mn_en_o), .fs_load_o(fs_load_o),
    .fs_code_o(fs_code_o)
  );

  // tmo[23:16] safe_en[15] safe[14:10] strap[9:5] expected_fs[4:0]
  localparam logic [23:0] VEC [5] = '{
    {8'd2, 1'b1, 5'h0A, 5'h13, 5'h0A},
    {8'd1, 1'b0, 5'h1F, 5'h06, 5'h06},
    {8'd3, 1'b1, 5'h15, 5'h00, 5'h15},
    {8'd0, 1'b0, 5'h02, 5'h1E, 5'h1E},
    {8'd5, 1'b1, 5'h00, 5'h11, 5'h00}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic tk, input logic tw, input logic [7:0] tv,
                     input logic ew, input logic ev, input logic mw, input logic mv);
    tick_i = tk; tmo_wr_i = tw; tmo_wdata_i = tv;
    en_wr_i = ew; en_wdata_i = ev; mn_wr_i = mw; mn_wdata_i = mv;
    @(negedge clk);
    tick_i = 0; tmo_wr_i = 0; en_wr_i = 0; en_wdata_i = 0; mn_wr_i = 0; mn_wdata_i = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 8'd0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 count", count_o, 8);
    chk("R1 running", running_o, 0);
    chk("R1 timeout", timeout_o, 0);
    chk("R1 rst_pull", rst_pull_o, 0);
    chk("R1 mn_en", mn_en_o, 0);
    chk("R1 fs_load", fs_load_o, 0);

    for (int v = 0; v < 5; v++) begin
      int tmo = VEC[v][23:16];
      int units = (tmo == 0) ? 1 : tmo;
      safe_en_i = VEC[v][15]; safe_code_i = VEC[v][14:10]; strap_fs_i = VEC[v][9:5];
      cyc(0, 0, 8'd0, 0, 0, 1, 1);
      chk("R6 mn set", mn_en_o, 1);
      cyc(0, 1, 8'(tmo), 0, 0, 0, 0);
      cyc(0, 0, 8'd0, 1, 1, 0, 0);
      chk("R2 load", count_o, tmo);
      chk("R2 running", running_o, 1);
      chk("R4 status cleared", timeout_o, 0);
      for (int u = 0; u < units - 1; u++) begin
        ticks(TPU);
        chk("R2 step", count_o, tmo - u - 1);
      end
      ticks(TPU - 1);
      chk("R3 not yet", timeout_o, 0);
      chk(tmo == 0 ? "R10 running" : "R2 running", running_o, 1);
      ticks(1);
      chk(tmo == 0 ? "R10 expire" : "R3 status", timeout_o, 1);
      chk("R3 stopped", running_o, 0);
      chk("R3 zero", count_o, 0);
      chk("R5 pull", rst_pull_o, 1);
      chk("R6 mn cleared", mn_en_o, 0);
      chk("R7 load", fs_load_o, 1);
      chk("R7 code", fs_code_o, VEC[v][4:0]);
      cyc(0, 0, 8'd0, 0, 0, 0, 0);
      chk("R7 load single", fs_load_o, 0);
      chk("R5 hold", rst_pull_o, 1);
      ticks(TPU - 1);
      chk("R5 still low", rst_pull_o, 1);
      chk("R4 sticky", timeout_o, 1);
      chk("R3 no wrap", count_o, 0);
      ticks(1);
      chk("R5 released", rst_pull_o, 0);
      chk("R7 code held", fs_code_o, VEC[v][4:0]);
    end

    // R9: stop mid-count
    cyc(0, 1, 8'd4, 0, 0, 0, 0);
    cyc(0, 0, 8'd0, 1, 1, 0, 0);
    chk("R4 cleared on restart", timeout_o, 0);
    ticks(TPU);
    chk("R9 step", count_o, 3);
    cyc(0, 0, 8'd0, 1, 0, 0, 0);
    chk("R9 stopped", running_o, 0);
    ticks(3 * TPU + 2);
    chk("R9 held", count_o, 3);
    chk("R9 no expire", timeout_o, 0);
    chk("R9 no pull", rst_pull_o, 0);

    // R8: keep-alive write on the expiry strobe
    cyc(0, 1, 8'd2, 0, 0, 0, 0);
    cyc(0, 0, 8'd0, 1, 1, 0, 0);
    ticks(2 * TPU - 1);
    chk("R8 pre count", count_o, 1);
    cyc(1, 1, 8'd3, 0, 0, 0, 0);
    chk("R8 no expire", timeout_o, 0);
    chk("R8 running", running_o, 1);
    chk("R8 reload", count_o, 3);
    chk("R8 no pull", rst_pull_o, 0);
    ticks(3 * TPU - 1);
    chk("R8 prescaler reloaded", timeout_o, 0);
    chk("R8 last unit", count_o, 1);
    ticks(1);
    chk("R8 expire later", timeout_o, 1);
    ticks(TPU);
    chk("R5 released", rst_pull_o, 0);

    // R6: M/N write collides with expiry
    cyc(0, 1, 8'd1, 0, 0, 0, 0);
    cyc(0, 0, 8'd0, 1, 1, 1, 1);
    chk("R6 mn set", mn_en_o, 1);
    ticks(TPU - 1);
    cyc(1, 0, 8'd0, 0, 0, 1, 1);
    chk("R6 expire", timeout_o, 1);
    chk("R6 clear wins", mn_en_o, 0);
    ticks(TPU);

    finish_run();
  end
endmodule